// File: doc/BRIEF.md
# Serial Port Line and Modem Status Unit

This block keeps the status of a serial port. It takes one-cycle event strobes from the receive path (word loaded, stop-bit fault, parity fault, long-low break, unread data overwritten) and stores them as sticky flags in a 16-bit line status word. It also registers two transmit-side emptiness levels. The error and break flags clear when software reads the line status word. The data-ready flag ignores that read and clears only when the receive data register is read.

A second 16-bit word reports four active-low handshake pins: carrier detect, ring, data-set-ready and clear-to-send. Each pin passes through a two-flop synchronizer and is then inverted, so a reported 1 means the pin is low. Both words are outputs at all times, and the bus logic around the block selects between them.

Top module: `uart_status_regs`

## Requirements
- R1: Reset sets the line status word to 0x0060 and the modem status word to 0x0000.
- R2: Line status bits 15:7 and modem status bits 15:8 and 3:0 always read as 0.
- R3: Line status bit 5 (holding register empty) equals `txHoldEmpty` as it was sampled on the previous clock edge.
- R4: Line status bit 6 (transmitter fully empty) is 1 only when `txHoldEmpty` and `txShiftEmpty` were both 1 at the previous clock edge.
- R5: The pulses `breakPulse`, `frameErrPulse`, `parityErrPulse` and `rxOverwritePulse` set line status bits 4, 3, 2 and 1 on the next edge. Each bit then stays set until it is cleared by R6.
- R6: When `rdLineStat` is high at an edge, bits 4:1 clear at that edge. A set pulse in the same cycle wins, and its bit reads 1 afterwards.
- R7: `rxWordLoaded` sets bit 0 (data ready). A line status read leaves bit 0 unchanged. `rdRxData` clears it, unless `rxWordLoaded` is high in the same cycle, in which case the bit stays set.
- R8: Modem status bits 7, 6, 5 and 4 are the inverses of `pinDcdN`, `pinRiN`, `pinDsrN` and `pinCtsN` sampled two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxWordLoaded | input | 1 | Pulse: a received word was stored |
| frameErrPulse | input | 1 | Pulse: invalid stop bit seen |
| parityErrPulse | input | 1 | Pulse: parity check failed |
| breakPulse | input | 1 | Pulse: input held low beyond a full frame |
| rxOverwritePulse | input | 1 | Pulse: unread receive data overwritten |
| txHoldEmpty | input | 1 | Level: transmit holding register empty |
| txShiftEmpty | input | 1 | Level: transmit shifter empty |
| rdLineStat | input | 1 | Bus read strobe of the line status word |
| rdRxData | input | 1 | Bus read strobe of the receive data register |
| pinDcdN | input | 1 | Carrier detect pin, active low |
| pinRiN | input | 1 | Ring pin, active low |
| pinDsrN | input | 1 | Data-set-ready pin, active low |
| pinCtsN | input | 1 | Clear-to-send pin, active low |
| lineStat | output | 16 | Line status word |
| modemStat | output | 16 | Modem status word |

## Verification
The assertions check on every cycle that the reserved bits stay zero, that the error flags hold until a line status read, and that a read clears them unless a set pulse arrives at the same edge. They also check that data ready survives everything except a receive data read, and that the transmit and modem bits follow their inputs with the stated latency. The reset values, full-word agreement with a reference model over long mixed sequences, and the interaction of several flags during one read can only be shown by the bench's scenarios.

// File: rtl/uart_status_pkg.sv
package uart_status_pkg;
  localparam int WORD_W   = 16;
  localparam int ERR_N    = 4;   // break, framing, parity, overrun
  localparam int PIN_N    = 4;   // dcd, ri, dsr, cts
  localparam int POS_DR   = 0;
  localparam int POS_ERR  = 1;   // bits 4:1
  localparam int POS_THRE = 5;
  localparam int POS_TEMT = 6;
  localparam int POS_PIN  = 4;   // modem bits 7:4

  typedef struct packed {
    logic             setDr;
    logic             clrDr;
    logic             clrErr;
    logic [ERR_N-1:0] setErr;   // [3]=break [2]=frame [1]=parity [0]=overrun
  } statStrobeT;
endpackage

// File: rtl/uart_status_ctrl.sv
module uart_status_ctrl
  import uart_status_pkg::*;
(
  input  logic       rxWordLoaded,
  input  logic       frameErrPulse,
  input  logic       parityErrPulse,
  input  logic       breakPulse,
  input  logic       rxOverwritePulse,
  input  logic       rdLineStat,
  input  logic       rdRxData,
  output statStrobeT strobes
);
  always_comb begin
    strobes.setDr  = rxWordLoaded;
    strobes.clrDr  = rdRxData;
    strobes.clrErr = rdLineStat;
    strobes.setErr = {breakPulse, frameErrPulse, parityErrPulse, rxOverwritePulse};
  end
endmodule

// File: rtl/uart_status_dp.sv
module uart_status_dp
  import uart_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrobeT        strobes,
  input  logic              txHoldEmpty,
  input  logic              txShiftEmpty,
  input  logic [PIN_N-1:0]  pinsN,      // [3]=dcd [2]=ri [1]=dsr [0]=cts
  output logic [WORD_W-1:0] lineStat,
  output logic [WORD_W-1:0] modemStat
);
  logic [ERR_N-1:0] errFlags;
  logic             dataReady;
  logic             holdEmptyQ;
  logic             allEmptyQ;
  logic [PIN_N-1:0] syncChain [SYNC_STAGES];

  // Sticky error flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (strobes.clrErr ? '0 : errFlags) | strobes.setErr;
  end

  // Data ready: cleared only by a receive data read
  always_ff @(posedge clk) begin
    if (!rstN) dataReady <= 1'b0;
    else       dataReady <= (dataReady & ~strobes.clrDr) | strobes.setDr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEmptyQ <= 1'b1;
      allEmptyQ  <= 1'b1;
    end else begin
      holdEmptyQ <= txHoldEmpty;
      allEmptyQ  <= txHoldEmpty & txShiftEmpty;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= '1;
          else       syncChain[s] <= pinsN;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[s] <= '1;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    lineStat = '0;
    lineStat[POS_DR]                  = dataReady;
    lineStat[POS_ERR +: ERR_N]        = errFlags;
    lineStat[POS_THRE]                = holdEmptyQ;
    lineStat[POS_TEMT]                = allEmptyQ;
    modemStat = '0;
    modemStat[POS_PIN +: PIN_N]       = ~syncChain[SYNC_STAGES-1];
  end
endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
  import uart_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxWordLoaded,
  input  logic        frameErrPulse,
  input  logic        parityErrPulse,
  input  logic        breakPulse,
  input  logic        rxOverwritePulse,
  input  logic        txHoldEmpty,
  input  logic        txShiftEmpty,
  input  logic        rdLineStat,
  input  logic        rdRxData,
  input  logic        pinDcdN,
  input  logic        pinRiN,
  input  logic        pinDsrN,
  input  logic        pinCtsN,
  output logic [15:0] lineStat,
  output logic [15:0] modemStat
);
  statStrobeT strobes;

  uart_status_ctrl uCtrl (
    .rxWordLoaded    (rxWordLoaded),
    .frameErrPulse   (frameErrPulse),
    .parityErrPulse  (parityErrPulse),
    .breakPulse      (breakPulse),
    .rxOverwritePulse(rxOverwritePulse),
    .rdLineStat      (rdLineStat),
    .rdRxData        (rdRxData),
    .strobes         (strobes)
  );

  uart_status_dp #(.SYNC_STAGES(2)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .txHoldEmpty (txHoldEmpty),
    .txShiftEmpty(txShiftEmpty),
    .pinsN       ({pinDcdN, pinRiN, pinDsrN, pinCtsN}),
    .lineStat    (lineStat),
    .modemStat   (modemStat)
  );
endmodule

// File: rtl/uart_status_regs_chk.sv
module uart_status_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rxWordLoaded,
  input logic        frameErrPulse,
  input logic        parityErrPulse,
  input logic        breakPulse,
  input logic        rxOverwritePulse,
  input logic        txHoldEmpty,
  input logic        txShiftEmpty,
  input logic        rdLineStat,
  input logic        rdRxData,
  input logic        pinDcdN,
  input logic        pinRiN,
  input logic        pinDsrN,
  input logic        pinCtsN,
  input logic [15:0] lineStat,
  input logic [15:0] modemStat
);
  logic [3:0] anySet;
  assign anySet = {breakPulse, frameErrPulse, parityErrPulse, rxOverwritePulse};

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    lineStat[15:7] == '0 && modemStat[15:8] == '0 && modemStat[3:0] == '0); // R2

  AST_THRE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> lineStat[5] == $past(txHoldEmpty)); // R3

  AST_TEMT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> lineStat[6] == ($past(txHoldEmpty) && $past(txShiftEmpty))); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !rdLineStat |=> (lineStat[4:1] & $past(lineStat[4:1])) == $past(lineStat[4:1])); // R5

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (anySet != '0) |=> (lineStat[4:1] & $past(anySet)) == $past(anySet)); // R5

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdLineStat && anySet == '0) |=> lineStat[4:1] == '0); // R6

  AST_DR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lineStat[0] && !rdRxData) |=> lineStat[0]); // R7

  AST_DR_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxWordLoaded |=> lineStat[0]); // R7

  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdRxData && !rxWordLoaded) |=> !lineStat[0]); // R7

  AST_MODEM_PINS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |->
      modemStat[7:4] == ~{$past(pinDcdN, 2), $past(pinRiN, 2), $past(pinDsrN, 2), $past(pinCtsN, 2)}); // R8
endmodule

bind uart_status_regs uart_status_regs_chk chk (.*);

// File: tb/uart_status_regs_test.sv
`timescale 1ns/1ps
module uart_status_regs_test;
  typedef struct {
    logic [15:0] line;
    logic [15:0] modem;
    string       tag;
  } expItemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxWordLoaded = 0, frameErrPulse = 0, parityErrPulse = 0, breakPulse = 0, rxOverwritePulse = 0;
  logic txHoldEmpty = 1, txShiftEmpty = 1, rdLineStat = 0, rdRxData = 0;
  logic pinDcdN = 1, pinRiN = 1, pinDsrN = 1, pinCtsN = 1;
  logic [15:0] lineStat, modemStat;

  expItemT expQ[$];
  int vecCount = 0;
  int missCount = 0;
  bit done = 0;

  // reference state
  logic [3:0] mErr = '0;
  logic       mDr = 0, mThre = 1, mTemt = 1;
  logic [3:0] mS1 = '1, mS2 = '1;

  always #10 clk = ~clk;

  uart_status_regs uut (.*);

  // Driver: apply one cycle of stimulus and push the expected post-edge words.
  // ev: [4]=break [3]=frame [2]=parity [1]=overwrite [0]=word loaded
  // pinsN: [3]=dcd [2]=ri [1]=dsr [0]=cts
  task automatic step(input logic rst, input logic [4:0] ev, input logic hold, input logic shift,
                      input logic rdL, input logic rdR, input logic [3:0] pinsN, input string tag);
    expItemT it;
    @(negedge clk);
    rstN = ~rst;
    {breakPulse, frameErrPulse, parityErrPulse, rxOverwritePulse, rxWordLoaded} = ev;
    txHoldEmpty = hold; txShiftEmpty = shift;
    rdLineStat = rdL; rdRxData = rdR;
    {pinDcdN, pinRiN, pinDsrN, pinCtsN} = pinsN;
    if (rst) begin
      mErr = '0; mDr = 0; mThre = 1; mTemt = 1; mS1 = '1; mS2 = '1;
    end else begin
      mErr  = (rdL ? 4'b0 : mErr) | ev[4:1];
      mDr   = (mDr & ~rdR) | ev[0];
      mThre = hold;
      mTemt = hold & shift;
      mS2   = mS1;
      mS1   = pinsN;
    end
    it.line  = {9'b0, mTemt, mThre, mErr, mDr};
    it.modem = {8'b0, ~mS2, 4'b0};
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n, input logic [3:0] pinsN, input string tag);
    for (int i = 0; i < n; i++) step(0, 5'b0, 1, 1, 0, 0, pinsN, tag);
  endtask

  // Monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (expQ.size() > 0) begin
        expItemT it;
        it = expQ.pop_front();
        vecCount++;
        if (lineStat !== it.line) begin
          missCount++;
          $display("FAIL %s line status: got %h expected %h", it.tag, lineStat, it.line);
        end
        vecCount++;
        if (modemStat !== it.modem) begin
          missCount++;
          $display("FAIL %s modem status: got %h expected %h", it.tag, modemStat, it.modem);
        end
        vecCount++;
        if (lineStat[15:7] !== 9'b0 || modemStat[15:8] !== 8'b0 || modemStat[3:0] !== 4'b0) begin
          missCount++;
          $display("FAIL R2 reserved bits: got line %h modem %h expected zeros", lineStat, modemStat);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    // R1 reset values, with inputs at non-idle levels during reset
    step(1, 5'b11111, 0, 0, 0, 0, 4'h0, "R1 reset");
    step(1, 5'b0, 1, 1, 0, 0, 4'hF, "R1 reset");
    idle(3, 4'hF, "R1 idle");

    // R5 each error flag sets and sticks
    step(0, 5'b10000, 1, 1, 0, 0, 4'hF, "R5 break");
    step(0, 5'b01000, 1, 1, 0, 0, 4'hF, "R5 frame");
    step(0, 5'b00100, 1, 1, 0, 0, 4'hF, "R5 parity");
    step(0, 5'b00010, 1, 1, 0, 0, 4'hF, "R5 overrun");
    idle(3, 4'hF, "R5 sticky");
    // R6 line read clears all error flags
    step(0, 5'b0, 1, 1, 1, 0, 4'hF, "R6 read clears");
    idle(2, 4'hF, "R6 after clear");
    // R6 set wins over read in the same cycle
    step(0, 5'b00100, 1, 1, 0, 0, 4'hF, "R6 setup");
    step(0, 5'b01000, 1, 1, 1, 0, 4'hF, "R6 set wins");
    idle(2, 4'hF, "R6 hold");
    step(0, 5'b0, 1, 1, 1, 0, 4'hF, "R6 clear");

    // R7 data ready
    step(0, 5'b00001, 1, 1, 0, 0, 4'hF, "R7 load");
    step(0, 5'b0, 1, 1, 1, 0, 4'hF, "R7 line read ignored");
    idle(2, 4'hF, "R7 hold");
    step(0, 5'b0, 1, 1, 0, 1, 4'hF, "R7 data read clears");
    step(0, 5'b00001, 1, 1, 0, 0, 4'hF, "R7 reload");
    step(0, 5'b00001, 1, 1, 0, 1, 4'hF, "R7 set wins");
    step(0, 5'b0, 1, 1, 0, 1, 4'hF, "R7 clear");

    // R3 / R4 transmit empties
    step(0, 5'b0, 0, 0, 0, 0, 4'hF, "R3 R4 both busy");
    step(0, 5'b0, 1, 0, 0, 0, 4'hF, "R3 hold empty shifter busy");
    step(0, 5'b0, 0, 1, 0, 0, 4'hF, "R4 shifter empty only");
    step(0, 5'b0, 1, 1, 0, 0, 4'hF, "R4 both empty");

    // R8 modem pins, one at a time then combos
    idle(3, 4'b0111, "R8 dcd low");
    idle(3, 4'b1011, "R8 ri low");
    idle(3, 4'b1101, "R8 dsr low");
    idle(3, 4'b1110, "R8 cts low");
    step(0, 5'b0, 1, 1, 0, 0, 4'h0, "R8 toggle");
    step(0, 5'b0, 1, 1, 0, 0, 4'hF, "R8 toggle");
    step(0, 5'b0, 1, 1, 0, 0, 4'h5, "R8 toggle");
    idle(3, 4'hA, "R8 pattern");

    // Mixed pseudo-random sequence against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(0, {r[0] & r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8] & r[9]},
           r[10] | r[11], r[12] | r[13], r[14] & r[15], r[16] & r[17], r[21:18],
           "R5 R6 R7 mixed");
    end

    // R1 reset mid-operation
    step(0, 5'b11111, 0, 0, 0, 0, 4'h0, "R1 pre-reset");
    step(1, 5'b0, 0, 0, 0, 0, 4'h0, "R1 re-reset");
    idle(3, 4'hF, "R1 after");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule